// File: doc/BRIEF.md
# Scatter/Gather Descriptor DMA Engine

This engine moves one storage command's worth of data between a sector buffer and system memory. The data's place in memory is described by a chain of region descriptors that also sit in memory. When the device side has a DMA command ready, the engine arms itself. The host then supplies the descriptor chain's base address with a start strobe. From that point the engine fetches each 8-byte descriptor and waits a storage latency that grows with the region's size. It then moves the region as a series of bursts, none of which crosses a page boundary. It stops after the region marked as last.

Each region's bytes are charged against the command's byte budget. A region larger than the remaining budget is an error. So is a last region that leaves budget unspent. Either one ends the command with an error pulse instead of a done pulse. The memory port is a simple master: one request cycle, then an acknowledge. A busy memory port makes the engine wait a fixed backoff period and try again. An abort input ends an armed or running command at once.

Top module: `prd_dma_engine`

## Requirements
- R1: The first descriptor fetch uses `table_base` with bits 1:0 forced to zero. Every fetch request has `mem_we`=0, `mem_len`=8 and `mem_addr[1:0]`=0.
- R2: `dma_state` reads 0 for Idle, 1 for Start and 2 for Transfer. A `cmd_ready` pulse in Idle moves to Start. A `start` pulse is acted on only in Start; in Idle it causes no memory request and the state stays 0.
- R3: After each descriptor fetch, the next fetch address is 8 bytes higher.
- R4: A descriptor holds the base address in bits 31:0, the byte count in bits 47:32 and the last-region flag in bit 63. A burst's length is the remaining region bytes, capped at one page (PAGE_BYTES, default 8192), and further cut so that the burst ends at the next page boundary. Consecutive bursts of a region are contiguous.
- R5: No request is issued in a cycle where `mem_busy` is 1. After a busy cycle, the retry request follows exactly BACKOFF+1 cycles later.
- R6: If a descriptor's byte count exceeds the command's remaining bytes, `error` pulses one cycle after the fetch acknowledge. No burst is issued and the engine returns to Idle.
- R7: When the last-region flag's region completes with zero bytes left, `done` pulses two cycles after the final burst acknowledge and the engine returns to Idle. If bytes are left, `error` pulses instead. When the region is not the last, the next fetch follows two cycles after the acknowledge.
- R8: With `cmd_disk_write`=1 the bursts are memory reads (`mem_we`=0). With `cmd_disk_write`=0 they are memory writes (`mem_we`=1).
- R9: The first fetch request comes in the cycle after the `start` cycle. The first burst of a region follows the fetch acknowledge after BASE_DELAY + count/512 cycles in between. A burst after a non-final burst follows its acknowledge directly.
- R10: `abort` in Start or Transfer returns the engine to Idle with an `error` pulse in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_ready | input | 1 | Device has a DMA command ready (arms the engine) |
| cmd_disk_write | input | 1 | 1: data goes to storage (memory reads); 0: data comes from storage (memory writes) |
| cmd_bytes | input | CNT_W | Byte budget of the command |
| table_base | input | AW | Descriptor chain base address |
| start | input | 1 | Start strobe |
| abort | input | 1 | Ends the command with an error |
| mem_req | output | 1 | Memory request valid for this cycle |
| mem_we | output | 1 | Request is a memory write |
| mem_addr | output | AW | Request byte address |
| mem_len | output | 16 | Request length in bytes |
| mem_busy | input | 1 | Memory port cannot take a request |
| mem_ack | input | 1 | Outstanding request completed |
| mem_rdata | input | 64 | Descriptor contents, valid with mem_ack |
| dma_state | output | 2 | 0 Idle, 1 Start, 2 Transfer |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle error pulse |

## Verification
A single-region chain whose region straddles a page boundary separates correct page splitting and read direction from a plain whole-region transfer. A two-region chain in the write direction exposes the pointer step, the inter-region timing and the per-region latency, which scales with size. A busy cycle placed on the first fetch, a region larger than the budget, a last region that leaves budget unspent, and aborts in both Start and Transfer each isolate one exit path. A start pulse while Idle checks that nothing is issued. Every memory request and every done or error pulse is matched in order against an expected queue, including its cycle distance from the preceding event.

// File: rtl/prd_dma_engine.sv
module prd_dma_engine #(
  parameter int AW           = 32,
  parameter int CNT_W        = 18,
  parameter int PAGE_BYTES   = 8192,
  parameter int SECTOR_BYTES = 512,
  parameter int BACKOFF      = 4,
  parameter int BASE_DELAY   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_ready,
  input  logic             cmd_disk_write,
  input  logic [CNT_W-1:0] cmd_bytes,
  input  logic [AW-1:0]    table_base,
  input  logic             start,
  input  logic             abort,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [15:0]      mem_len,
  input  logic             mem_busy,
  input  logic             mem_ack,
  input  logic [63:0]      mem_rdata,
  output logic [1:0]       dma_state,
  output logic             done,
  output logic             error
);
  localparam int PG_W  = $clog2(PAGE_BYTES);
  localparam int SEC_W = $clog2(SECTOR_BYTES);

  typedef enum logic [3:0] {
    P_IDLE, P_START, P_FETCH, P_FWAIT, P_DELAY, P_BURST, P_BWAIT, P_BACK, P_END
  } ph_t;

  ph_t             ph;
  logic [AW-1:0]   ptr, rg_addr;
  logic [15:0]     rg_rem, cnt;
  logic            rg_eot, dir_wr, ret_burst;
  logic [CNT_W-1:0] left;

  logic [31:0] d_base;
  logic [15:0] d_cnt;
  logic        d_eot;
  logic        unused_rsvd;
  assign d_base = mem_rdata[31:0];
  assign d_cnt  = mem_rdata[47:32];
  assign d_eot  = mem_rdata[63];
  assign unused_rsvd = ^mem_rdata[62:48];

  logic [16:0] page_left, cap, blen;
  assign page_left = 17'(PAGE_BYTES) - 17'(rg_addr[PG_W-1:0]);
  assign cap  = (17'(rg_rem) > 17'(PAGE_BYTES)) ? 17'(PAGE_BYTES) : 17'(rg_rem);
  assign blen = (cap > page_left) ? page_left : cap;

  assign mem_req   = (ph == P_FETCH || ph == P_BURST) && !mem_busy;
  assign mem_we    = (ph == P_BURST) && !dir_wr;
  assign mem_addr  = (ph == P_FETCH) ? ptr : rg_addr;
  assign mem_len   = (ph == P_FETCH) ? 16'd8 : blen[15:0];
  assign dma_state = (ph == P_IDLE) ? 2'd0 : (ph == P_START) ? 2'd1 : 2'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= P_IDLE; ptr <= '0; rg_addr <= '0; rg_rem <= '0; cnt <= '0;
      rg_eot <= 1'b0; dir_wr <= 1'b0; ret_burst <= 1'b0; left <= '0;
      done <= 1'b0; error <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      if (abort && ph != P_IDLE) begin
        ph    <= P_IDLE;
        error <= 1'b1;
      end else begin
        case (ph)
          P_IDLE: if (cmd_ready) begin
            ph     <= P_START;
            dir_wr <= cmd_disk_write;
            left   <= cmd_bytes;
          end
          P_START: if (start) begin
            ptr <= {table_base[AW-1:2], 2'b00};
            ph  <= P_FETCH;
          end
          P_FETCH, P_BURST: begin
            if (mem_busy) begin
              cnt       <= 16'(BACKOFF - 1);
              ret_burst <= (ph == P_BURST);
              ph        <= P_BACK;
            end else begin
              ph <= (ph == P_FETCH) ? P_FWAIT : P_BWAIT;
            end
          end
          P_BACK: begin
            if (cnt == 16'd0) ph <= ret_burst ? P_BURST : P_FETCH;
            else cnt <= cnt - 16'd1;
          end
          P_FWAIT: if (mem_ack) begin
            ptr <= ptr + AW'(8);
            if (CNT_W'(d_cnt) > left) begin
              ph    <= P_IDLE;
              error <= 1'b1;
            end else begin
              rg_addr <= AW'(d_base);
              rg_rem  <= d_cnt;
              rg_eot  <= d_eot;
              cnt     <= 16'(BASE_DELAY) + (d_cnt >> SEC_W) - 16'd1;
              ph      <= P_DELAY;
            end
          end
          P_DELAY: begin
            if (cnt == 16'd0) ph <= (rg_rem == 16'd0) ? P_END : P_BURST;
            else cnt <= cnt - 16'd1;
          end
          P_BWAIT: if (mem_ack) begin
            rg_addr <= rg_addr + AW'(blen);
            rg_rem  <= rg_rem - blen[15:0];
            left    <= left - CNT_W'(blen);
            ph      <= (17'(rg_rem) == blen) ? P_END : P_BURST;
          end
          P_END: begin
            if (rg_eot) begin
              ph <= P_IDLE;
              if (left == '0) done <= 1'b1;
              else error <= 1'b1;
            end else begin
              ph <= P_FETCH;
            end
          end
          default: ph <= P_IDLE;
        endcase
      end
    end
  end

  p_tbl_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && ph == P_FETCH) |-> (mem_addr[1:0] == 2'b00 && !mem_we));
  p_start_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == P_IDLE && start) |=> (ph != P_FETCH));
  p_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && ph == P_BURST) |->
      ((32'(mem_addr[PG_W-1:0]) + 32'(mem_len)) <= 32'(PAGE_BYTES) && mem_len != 16'd0));
  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_busy && (ph == P_FETCH || ph == P_BURST) && !abort) |=> !mem_req);
  p_done_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (left == '0 && dma_state == 2'd0 && !error));
  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && ph != P_IDLE) |=> (error && dma_state == 2'd0));
endmodule

// File: tb/sim_prd_dma_engine.sv
module sim_prd_dma_engine;
  localparam int BO = 4;
  localparam int BD = 2;

  logic        clk, rst_n, cmd_ready, cmd_disk_write, start, abort;
  logic [17:0] cmd_bytes;
  logic [31:0] table_base, mem_addr;
  logic        mem_req, mem_we, mem_busy, mem_ack, done, error;
  logic [15:0] mem_len;
  logic [63:0] mem_rdata;
  logic [1:0]  dma_state;

  prd_dma_engine #(.BACKOFF(BO), .BASE_DELAY(BD)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .cmd_disk_write(cmd_disk_write),
    .cmd_bytes(cmd_bytes), .table_base(table_base), .start(start), .abort(abort),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_len(mem_len),
    .mem_busy(mem_busy), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .dma_state(dma_state), .done(done), .error(error));

  initial clk = 0;
  always #5 clk = ~clk;

  typedef struct {int kind; int addr; int len; int we; int gap; string tag;} item_t;
  item_t q[$];
  logic [63:0] dmem [int];
  int cyc = 0, busy_at = -1, ack_due = -1, last_ev = 0, pend_addr = 0;
  int checks = 0, fails = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic exp_req(input int a, input int l, input int w, input int g, input string t);
    item_t it;
    it.kind = 0; it.addr = a; it.len = l; it.we = w; it.gap = g; it.tag = t;
    q.push_back(it);
  endtask

  task automatic exp_end(input int k, input int g, input string t);
    item_t it;
    it.kind = k; it.addr = 0; it.len = 0; it.we = 0; it.gap = g; it.tag = t;
    q.push_back(it);
  endtask

  function automatic logic [63:0] desc(input int base, input int count, input bit eot);
    return {eot, 15'd0, 16'(count), 32'(base)};
  endfunction

  // memory model and monitor
  always @(negedge clk) begin
    mem_busy = (cyc == busy_at);
    mem_ack  = (cyc == ack_due);
    if (mem_ack) begin
      last_ev   = cyc;
      mem_rdata = dmem.exists(pend_addr) ? dmem[pend_addr] : 64'd0;
    end
    #2;
    if (rst_n) begin
      if (mem_req && mem_busy) chk(0, "R5", "request while busy", 1, 0);
      if (mem_req || done || error) begin
        int kind;
        kind = mem_req ? 0 : (done ? 1 : 2);
        if (q.size() == 0) chk(0, "R2", "unexpected event kind", kind, -1);
        else begin
          item_t it;
          it = q.pop_front();
          chk(kind == it.kind, it.tag, "event kind", kind, it.kind);
          if (kind == 0 && it.kind == 0) begin
            chk(int'(mem_addr) == it.addr, it.tag, "addr", int'(mem_addr), it.addr);
            chk(int'(mem_len) == it.len, it.tag, "len", int'(mem_len), it.len);
            chk(int'(mem_we) == it.we, it.tag, "we", int'(mem_we), it.we);
          end
          if (it.gap >= 0) chk(cyc - last_ev - 1 == it.gap, it.tag, "cycle gap", cyc - last_ev - 1, it.gap);
        end
        if (mem_req) begin
          ack_due   = cyc + 2;
          pend_addr = int'(mem_addr);
        end
      end
    end
  end

  task automatic arm(input bit dw, input int bytes);
    @(negedge clk);
    cmd_ready = 1; cmd_disk_write = dw; cmd_bytes = 18'(bytes);
    @(negedge clk);
    cmd_ready = 0;
    #3 chk(dma_state == 2'd1, "R2", "state after cmd_ready", int'(dma_state), 1);
  endtask

  task automatic run_cmd(input bit dw, input int bytes, input int base, input int busy_off, input int abort_after);
    arm(dw, bytes);
    @(negedge clk);
    table_base = 32'(base); start = 1; last_ev = cyc;
    if (busy_off >= 0) busy_at = cyc + busy_off;
    @(negedge clk);
    start = 0;
    if (abort_after >= 0) begin
      repeat (abort_after) @(negedge clk);
      abort = 1; last_ev = cyc;
      @(negedge clk);
      abort = 0;
    end
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      #3;
      if (q.size() == 0 && dma_state == 2'd0) break;
    end
    chk(q.size() == 0, "R7", "pending expected events", q.size(), 0);
    chk(dma_state == 2'd0, "R7", "back to idle", int'(dma_state), 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    wait (cyc == 50000);
    chk(0, "R2", "watchdog expired", cyc, 0);
    report();
  end

  initial begin
    rst_n = 0; cmd_ready = 0; cmd_disk_write = 0; cmd_bytes = '0; table_base = '0;
    start = 0; abort = 0; mem_busy = 0; mem_ack = 0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #3;
    chk(dma_state == 2'd0 && !mem_req && !done && !error, "R2", "reset state",
        {dma_state, mem_req, done, error}, 0);

    // R2: start while Idle is ignored
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (5) @(negedge clk);
    #3 chk(dma_state == 2'd0, "R2", "start in idle ignored", int'(dma_state), 0);

    // R1 R4 R8 R9: one region straddling a page, disk write -> memory reads
    dmem[32'h1000] = desc(32'h1F00, 1024, 1);
    exp_req(32'h1000, 8, 0, 0, "R1");
    exp_req(32'h1F00, 256, 0, BD + 2, "R4");
    exp_req(32'h2000, 768, 0, 0, "R8");
    exp_end(1, 1, "R7");
    run_cmd(1, 1024, 32'h1003, -1, -1);

    // R3 R8 R9: two regions, disk read -> memory writes
    dmem[32'h3000] = desc(32'h10000, 512, 0);
    dmem[32'h3008] = desc(32'h20000, 1024, 1);
    exp_req(32'h3000, 8, 0, 0, "R9");
    exp_req(32'h10000, 512, 1, BD + 1, "R8");
    exp_req(32'h3008, 8, 0, 1, "R3");
    exp_req(32'h20000, 1024, 1, BD + 2, "R9");
    exp_end(1, 1, "R7");
    run_cmd(0, 1536, 32'h3000, -1, -1);

    // R5: busy on the first fetch
    dmem[32'h4000] = desc(32'h5000, 512, 1);
    exp_req(32'h4000, 8, 0, BO + 1, "R5");
    exp_req(32'h5000, 512, 0, BD + 1, "R5");
    exp_end(1, 1, "R7");
    run_cmd(1, 512, 32'h4000, 1, -1);

    // R6: region larger than budget
    dmem[32'h6000] = desc(32'h7000, 1024, 1);
    exp_req(32'h6000, 8, 0, 0, "R6");
    exp_end(2, 0, "R6");
    run_cmd(1, 512, 32'h6000, -1, -1);

    // R7: last region leaves budget unspent
    dmem[32'h8000] = desc(32'h9000, 512, 1);
    exp_req(32'h8000, 8, 0, 0, "R7");
    exp_req(32'h9000, 512, 1, BD + 1, "R7");
    exp_end(2, 1, "R7");
    run_cmd(0, 1024, 32'h8000, -1, -1);

    // R10: abort during region latency
    dmem[32'hA000] = desc(32'hB000, 4096, 1);
    exp_req(32'hA000, 8, 0, 0, "R10");
    exp_end(2, 0, "R10");
    run_cmd(1, 4096, 32'hA000, -1, 5);

    // R10: abort while armed in Start
    arm(1, 512);
    exp_end(2, 0, "R10");
    @(negedge clk); abort = 1; last_ev = cyc;
    @(negedge clk); abort = 0;
    #3 chk(dma_state == 2'd0, "R10", "idle after abort in start", int'(dma_state), 0);
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R10", "abort error seen", q.size(), 0);

    report();
  end
endmodule